// File: doc/BRIEF.md
# Slot-Table Bus Arbiter with Guaranteed Shares

This block decides, once per bus slot, which master may use a shared on-chip memory bus. One master, index 0, is the processor and its caches. The others are DMA engines. Time is cut into repeating frames of `FRAME_SLOTS` slots, and each grant covers exactly one slot, which here is one clock cycle. A programmable table names an owner for every slot in the frame. The number of slots a master owns sets its minimum bandwidth share, and the spacing of those slots bounds how long it can wait.

If the owner of the current slot is not requesting, the slot is not wasted. The processor gets it first, and its grant appears on the next cycle. When the processor is also idle, the DMA masters share the slot in round-robin order. Software rewrites owners through a one-entry-per-cycle configuration port. New entries are held in a shadow copy and take effect only when a frame begins, so a frame never loses a slot or hands one out twice.

Grants are registered and one-hot. A master gets a grant only if it was requesting at the clock edge that produced it.

Top module: `gbw_bus_arbiter`

## Requirements
- R1: After reset the grant vector is all zero, slot counting starts at slot 0, and slot k of both table copies is owned by master k mod NUM_MASTERS.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: A grant bit is high only if that master's `req` bit was high at the clock edge that set the grant.
- R4: If the owner of the current slot requests at an edge, the grant vector after that edge selects that owner (bit index = owner number).
- R5: If the slot owner is idle and master 0 requests, master 0 is granted in the next cycle.
- R6: If the slot owner and master 0 are both idle, the slot goes to the first requesting master found by scanning masters 1..NUM_MASTERS-1 cyclically, starting just after the last master that won a slot this way. That pointer is NUM_MASTERS-1 after reset and changes only on such an award.
- R7: With no request at an edge, the grant vector after that edge is all zero.
- R8: A write (`cfg_we`, slot number `cfg_slot`, owner number `cfg_owner`) changes only the shadow entry. The whole shadow table, including a write made in the frame's last slot, becomes active at the start of the next frame. The frame in progress keeps its old owners.
- R9: In a frame where every master requests in every slot, each master receives at least as many grants as slots it owns.
- R10: A master that owns at least one slot and holds its request is granted within FRAME_SLOTS cycles, as long as the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one bus slot |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_MASTERS | Request per master; bit 0 is the processor/cache master |
| cfg_we | input | 1 | Write strobe for one slot-table entry |
| cfg_slot | input | $clog2(FRAME_SLOTS) | Slot number being written |
| cfg_owner | input | $clog2(NUM_MASTERS) | Owner number written into that slot |
| gnt | output | NUM_MASTERS | Registered one-hot grant for the current slot |

## Verification
Every master requesting on every slot leaves no idle slot to share. This case shows the table alone: the default owner order and the per-frame share counts. Traffic with only the processor, or only two DMA masters, leaves the owned slots idle. That separates the processor-first leftover rule from the round-robin rotation and its pointer. A table rewrite issued partway through a fully loaded frame shows whether the old owners hold until the frame boundary. Seeded random request patterns, with and without table writes, are compared against a reference model cycle by cycle. In a phase with a fixed table, the wait of each owning master is measured against the frame length.

// File: rtl/gbw_arb_pkg.sv
package gbw_arb_pkg;

    localparam int MAX_MASTERS = 16;
    localparam int MAX_IDW     = 4;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_OWNER = 2'd1,
        SRC_CPU   = 2'd2,
        SRC_ROT   = 2'd3
    } grant_src_e;

    typedef struct packed {
        logic               hit;
        logic [MAX_IDW-1:0] idx;
    } rot_pick_t;

    // Cyclic scan over masters 1..n-1, beginning just after 'last'.
    function automatic rot_pick_t rot_scan(input logic [MAX_MASTERS-1:0] reqs,
                                           input logic [MAX_IDW-1:0]     last,
                                           input int                     n);
        rot_pick_t res;
        int        cand;
        res.hit = 1'b0;
        res.idx = '0;
        for (int k = 1; k < MAX_MASTERS; k++) begin
            if (k < n) begin
                cand = ((int'(last) - 1 + k) % (n - 1)) + 1;
                if (!res.hit && reqs[cand]) begin
                    res.hit = 1'b1;
                    res.idx = MAX_IDW'(cand);
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/gbw_slot_seq.sv
module gbw_slot_seq #(
    parameter int FRAME_SLOTS = 8,
    localparam int SW = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_idx,
    output logic          frame_end
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(FRAME_SLOTS - 1);

    logic [SW-1:0] slot_q;

    assign frame_end = (slot_q == LAST_SLOT);
    assign slot_idx  = slot_q;

    always_ff @(posedge clk) begin
        if (rst)            slot_q <= '0;
        else if (frame_end) slot_q <= '0;
        else                slot_q <= slot_q + SW'(1);
    end

    // R1
    slot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_q <= LAST_SLOT);

endmodule

// File: rtl/gbw_slot_table.sv
module gbw_slot_table #(
    parameter int NUM_MASTERS = 4,
    parameter int FRAME_SLOTS = 8,
    localparam int SW  = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1,
    localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [SW-1:0]  wr_slot,
    input  logic [IDW-1:0] wr_owner,
    input  logic           frame_end,
    input  logic [SW-1:0]  rd_slot,
    output logic [IDW-1:0] rd_owner
);
    logic [IDW-1:0] shadow_q [FRAME_SLOTS];
    logic [IDW-1:0] active_q [FRAME_SLOTS];
    logic           owner_ok;

    assign owner_ok = (int'(wr_owner) < NUM_MASTERS);
    assign rd_owner = active_q[rd_slot];

    for (genvar k = 0; k < FRAME_SLOTS; k++) begin : g_entry
        localparam logic [IDW-1:0] RST_OWNER = IDW'(k % NUM_MASTERS);
        logic hit;
        assign hit = wr_en && owner_ok && (wr_slot == SW'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[k] <= RST_OWNER;
                active_q[k] <= RST_OWNER;
            end else begin
                if (hit) shadow_q[k] <= wr_owner;
                if (frame_end) active_q[k] <= hit ? wr_owner : shadow_q[k];
            end
        end

        // R8
        active_frozen_chk: assert property (@(posedge clk) disable iff (rst)
            !frame_end |=> $stable(active_q[k]));
    end

endmodule

// File: rtl/gbw_grant_pick.sv
module gbw_grant_pick
    import gbw_arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] reqs,
    input  logic [IDW-1:0]         owner,
    input  logic [IDW-1:0]         last_rot,
    output logic                   win_valid,
    output logic [IDW-1:0]         win_idx,
    output grant_src_e             win_src
);
    logic [MAX_MASTERS-1:0] req_wide;
    logic [MAX_IDW-1:0]     last_wide;
    rot_pick_t              rot;

    assign req_wide  = MAX_MASTERS'(reqs);
    assign last_wide = MAX_IDW'(last_rot);
    assign rot       = rot_scan(req_wide, last_wide, NUM_MASTERS);

    always_comb begin
        win_valid = 1'b1;
        win_idx   = owner;
        win_src   = SRC_OWNER;
        if (!reqs[owner]) begin
            if (reqs[0]) begin
                win_idx = '0;
                win_src = SRC_CPU;
            end else if (rot.hit) begin
                win_idx = IDW'(rot.idx);
                win_src = SRC_ROT;
            end else begin
                win_valid = 1'b0;
                win_idx   = '0;
                win_src   = SRC_NONE;
            end
        end
    end

endmodule

// File: rtl/gbw_bus_arbiter.sv
module gbw_bus_arbiter
    import gbw_arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int FRAME_SLOTS = 8,
    localparam int SW  = (FRAME_SLOTS > 1) ? $clog2(FRAME_SLOTS) : 1,
    localparam int IDW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   cfg_we,
    input  logic [SW-1:0]          cfg_slot,
    input  logic [IDW-1:0]         cfg_owner,
    output logic [NUM_MASTERS-1:0] gnt
);
    logic [SW-1:0]          slot_idx;
    logic                   frame_end;
    logic [IDW-1:0]         owner;
    logic                   win_valid;
    logic [IDW-1:0]         win_idx;
    grant_src_e             win_src;
    logic [NUM_MASTERS-1:0] gnt_q;
    logic [IDW-1:0]         last_rot_q;

    gbw_slot_seq #(.FRAME_SLOTS(FRAME_SLOTS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .slot_idx  (slot_idx),
        .frame_end (frame_end)
    );

    gbw_slot_table #(.NUM_MASTERS(NUM_MASTERS), .FRAME_SLOTS(FRAME_SLOTS)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_slot   (cfg_slot),
        .wr_owner  (cfg_owner),
        .frame_end (frame_end),
        .rd_slot   (slot_idx),
        .rd_owner  (owner)
    );

    gbw_grant_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .reqs      (req),
        .owner     (owner),
        .last_rot  (last_rot_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_src   (win_src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q      <= '0;
            last_rot_q <= IDW'(NUM_MASTERS - 1);
        end else begin
            gnt_q <= win_valid ? (NUM_MASTERS'(1) << win_idx) : '0;
            if (win_src == SRC_ROT) last_rot_q <= win_idx;
        end
    end

    assign gnt = gnt_q;

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q));

    // R3
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        req[win_idx] |=> ((gnt_q & ~$past(req)) == '0));

    // R4
    owner_wins_chk: assert property (@(posedge clk) disable iff (rst)
        req[owner] |=> gnt_q[$past(owner)]);

    // R5
    cpu_leftover_chk: assert property (@(posedge clk) disable iff (rst)
        (!req[owner] && req[0]) |=> gnt_q[0]);

    // R7
    idle_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (gnt_q == '0));

endmodule

// File: tb/gbw_bus_arbiter_bench.sv
module gbw_bus_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int M  = 4;
    localparam int N  = 8;
    localparam int SW = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [M-1:0]  req = '0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_slot = '0;
    logic [IW-1:0] cfg_owner = '0;
    logic [M-1:0]  gnt;

    int checks = 0;
    int fails  = 0;

    int act_m [N];
    int shd_m [N];
    int slot_m;
    int last_m;
    int cnt_m [M];
    bit full_frame;
    bit lat_on;
    int wt [M];
    int max_wt;

    gbw_bus_arbiter #(.NUM_MASTERS(M), .FRAME_SLOTS(N)) u_gbw_bus_arbiter (
        .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we),
        .cfg_slot(cfg_slot), .cfg_owner(cfg_owner), .gnt(gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Expected winner from the requirements R4..R7; src 0 none,1 owner,2 cpu,3 rot
    function automatic int exp_win(input logic [M-1:0] r, input int own,
                                   input int last, output int src);
        src = 0;
        if (r[own]) begin src = 1; return own; end
        if (r[0])   begin src = 2; return 0;   end
        for (int k = 1; k < M; k++) begin
            int c = ((last - 1 + k) % (M - 1)) + 1;
            if (r[c]) begin src = 3; return c; end
        end
        return -1;
    endfunction

    function automatic int owned(input int m);
        int n = 0;
        for (int k = 0; k < N; k++) if (act_m[k] == m) n++;
        return n;
    endfunction

    task automatic step(input logic [M-1:0] r, input bit we, input int a,
                        input int o, input string tag);
        int src, win;
        logic [M-1:0] ev;
        string t;
        req = r; cfg_we = we; cfg_slot = SW'(a); cfg_owner = IW'(o);
        win = exp_win(r, act_m[slot_m], last_m, src);
        ev  = (win >= 0) ? (M'(1) << win) : '0;
        if (src == 3) last_m = win;
        if (win >= 0) cnt_m[win]++;
        if (r != '1) full_frame = 0;
        if (we) shd_m[a] = o;
        if (slot_m == N - 1) begin
            if (full_frame)
                for (int i = 0; i < M; i++)
                    check(cnt_m[i] >= owned(i), "R9 share", cnt_m[i], owned(i));
            for (int k = 0; k < N; k++) act_m[k] = shd_m[k];
            for (int i = 0; i < M; i++) cnt_m[i] = 0;
            full_frame = 1;
            slot_m = 0;
        end else slot_m++;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        t = tag;
        if (t == "") t = (src == 1) ? "R4" : (src == 2) ? "R5" : (src == 3) ? "R6" : "R7";
        check(gnt == ev, t, gnt, ev);
        check($countones(gnt) <= 1, "R2 onehot", gnt, ev);
        check((gnt & ~r) == '0, "R3 req", gnt, r);
        if (lat_on)
            for (int i = 0; i < M; i++) begin
                if (r[i] && !gnt[i] && owned(i) > 0) wt[i]++;
                else wt[i] = 0;
                if (wt[i] > max_wt) max_wt = wt[i];
            end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1);
        for (int k = 0; k < N; k++) begin act_m[k] = k % M; shd_m[k] = k % M; end
        for (int i = 0; i < M; i++) begin cnt_m[i] = 0; wt[i] = 0; end
        slot_m = 0; last_m = M - 1; full_frame = 1; lat_on = 0; max_wt = 0;
        repeat (3) @(negedge clk);
        check(gnt == '0, "R1 reset gnt", gnt, 0);
        rst = 1'b0;

        // R1: default owners k mod M under full load
        for (int k = 0; k < N; k++) step('1, 0, 0, 0, "R1");
        // R7
        repeat (3) step('0, 0, 0, 0, "");
        // R5: only the CPU asks
        repeat (8) step(4'b0001, 0, 0, 0, "");
        // R6: two DMA masters share slots owned by idle masters
        repeat (16) step(4'b0110, 0, 0, 0, "");
        repeat (8) step(4'b1010, 0, 0, 0, "");

        // R8: rewrite table mid-frame under full load
        while (slot_m != 2) step('1, 0, 0, 0, "");
        step('1, 1, 0, 1, "R8");
        step('1, 1, 1, 1, "R8");
        step('1, 1, 2, 2, "R8");
        step('1, 1, 3, 3, "R8");
        step('1, 1, 4, 3, "R8");
        step('1, 1, 7, 2, "R8");
        step('1, 1, 5, 3, "R8");
        step('1, 1, 6, 0, "R8");
        // R9: several fully loaded frames with the new table
        for (int k = 0; k < 3 * N; k++) step('1, 0, 0, 0, "");

        // R10: fixed table, random requests, waits tracked
        lat_on = 1;
        for (int k = 0; k < 400; k++) begin
            logic [M-1:0] r = M'($urandom);
            if (($urandom % 4) != 0) r = r | 4'b1110;
            step(r, 0, 0, 0, "");
        end
        lat_on = 0;
        check(max_wt < N, "R10 wait", max_wt, N - 1);

        // random traffic with table writes
        for (int k = 0; k < 1500; k++) begin
            logic [M-1:0] r = M'($urandom);
            bit w = (($urandom % 5) == 0);
            step(r, w, int'($urandom % N), int'($urandom % M), "");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule